// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the data mover of a multi-channel DMA controller. It holds, for each channel, a source address, a destination address, a next-descriptor pointer, a control word and a configuration word. On every arbitration pass it picks the lowest-numbered channel that is enabled, not halted and whose peripheral request lines match its flow type. It then moves exactly one data element: one read from the source and one write to the destination, both over a single-beat valid/ready memory master port.

After each element the remaining count in the control word goes down by one. When it reaches zero, the channel either loads a fresh four-word descriptor from memory, starting at its next pointer, or it switches itself off. A completing descriptor whose interrupt bit is set produces a one-cycle terminal-count pulse on that channel's line. Channel registers are written and read through a plain register port. Only the engine itself can change them, apart from that port.

The memory port carries one access at a time. The engine raises `mem_valid` and holds address, direction, byte enables and write data steady until the cycle in which `mem_ready` is high. That cycle completes the access, and for a read `mem_rdata` is taken in the same cycle. The memory may stall for any number of cycles.

Top module: `dma_ll_engine`

## Requirements
- R1: No channel is granted while `glob_en` is low. A grant is made only in a cycle where `glob_en` is sampled high.
- R2: A channel is a candidate only when its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: Configuration bits [13:11] select the flow type, bits [5:1] the source peripheral and bits [10:6] the destination peripheral. Type 0 needs no request, type 1 needs the destination line, type 2 needs the source line, type 3 needs both, and types 4 to 7 are never eligible. The request line vector is `req_single | req_burst`, and peripheral numbers at or above REQW count as inactive.
- R4: Each pass moves one element for the lowest-indexed eligible channel, so a lower index always wins.
- R5: The source element is 1, 2 or 4 bytes for control[20:18] = 0, 1, or 2 and above. The destination element is sized the same way from control[23:21]. The source bytes are taken from the byte lanes given by the source address, then zero-extended or truncated to the destination size, and written on the lanes given by the destination address.
- R6: Control bit 26 advances the source address, and bit 27 the destination address, by that side's element size after each element.
- R7: After each element, control[11:0] is written back decremented by one, and control[31:12] is kept unchanged.
- R8: When the count reaches zero and the next pointer P is nonzero, the engine reads four words from P+0, P+4, P+8 and P+12 in that order. These load the source, destination, next pointer and control registers. When the count reaches zero and P is zero, the engine clears configuration bit 0 instead.
- R9: When the count reaches zero and bit 31 of the control word that just finished is set, `tc_pulse` for that channel is high for exactly one cycle. The pulse starts one clock after the final write is accepted, and at most one bit is high at a time.
- R10: While `mem_valid` is high and `mem_ready` is low, address, direction, byte enables and write data stay unchanged. Only one access is in flight at a time.
- R11: Element reads enable only the source lanes. Descriptor reads enable all four lanes. `mem_be` is never zero while `mem_valid` is high.
- R12: After reset, all channel registers read zero, `mem_valid` is low and no terminal-count pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glob_en | input | 1 | Controller enable |
| req_single | input | REQW | Single-request lines from peripherals |
| req_burst | input | REQW | Burst-request lines from peripherals |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel selected for register access |
| cfg_sel | input | 3 | Register select: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| chan_en | output | NCH | Configuration enable bit of each channel |
| tc_pulse | output | NCH | Terminal-count pulse per channel |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access in this cycle |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-aligned |
| mem_rdata | input | 32 | Read data of the aligned word, taken when `mem_ready` is high |

## Verification
A grant is sampled in the idle cycle, so the source read request appears on the port one clock later. The destination write follows the clock after the read is accepted. The count, address and enable updates are made one clock after the write is accepted, and `tc_pulse` and `chan_en` show them from then on. Descriptor reads follow that update cycle directly. The bench answers each request after a rotating stall of zero to two cycles. It compares every accepted access against its reference model at the negative edge following the accepting edge. It changes request lines and registers only while the engine is quiet, and reads registers back only once the port has been idle for several cycles, so that every pending update has landed.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_WR   = 3'd2,
    S_UPD  = 3'd3,
    S_DSC  = 3'd4
  } st_t;

  localparam int CF_EN   = 0;
  localparam int CF_HALT = 18;
  localparam int CT_SINC = 26;
  localparam int CT_DINC = 27;
  localparam int CT_TCI  = 31;

  // log2 of element bytes; codes of 2 and above mean a full word
  function automatic logic [1:0] wlog(input logic [2:0] code);
    return (code >= 3'd2) ? 2'd2 : code[1:0];
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lg, input logic [1:0] off);
    logic [3:0] m;
    case (lg)
      2'd0:    m = 4'b0001;
      2'd1:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m << off;
  endfunction

  function automatic logic [31:0] data_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_ll_arb.sv
module dma_ll_arb
  import dma_ll_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int REQW = 16,
  parameter int CHW  = 1
) (
  input  logic [31:0]     cfg [NCH],
  input  logic [REQW-1:0] req,
  output logic            hit,
  output logic [CHW-1:0]  pick
);
  logic [31:0]    req_pad;
  logic [NCH-1:0] elig;

  assign req_pad = 32'(req);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rs, rd, ok;
    always_comb begin
      rs = req_pad[cfg[c][5:1]];
      rd = req_pad[cfg[c][10:6]];
      case (cfg[c][13:11])
        3'd0:    ok = 1'b1;
        3'd1:    ok = rd;
        3'd2:    ok = rs;
        3'd3:    ok = rs & rd;
        default: ok = 1'b0;
      endcase
      elig[c] = cfg[c][CF_EN] & ~cfg[c][CF_HALT] & ok;
    end
  end

  always_comb begin
    hit  = |elig;
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (elig[c]) pick = CHW'(c);
    end
  end
endmodule

// File: rtl/dma_ll_lane.sv
module dma_ll_lane
  import dma_ll_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  s_off,
  input  logic [1:0]  s_lg,
  input  logic [1:0]  d_off,
  input  logic [1:0]  d_lg,
  output logic [31:0] wdata,
  output logic [3:0]  wbe
);
  logic [31:0] elem;

  always_comb begin
    elem  = (word >> {s_off, 3'b000}) & data_mask(s_lg);
    wdata = (elem & data_mask(d_lg)) << {d_off, 3'b000};
    wbe   = lane_mask(d_lg, d_off);
  end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_ll_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int REQW = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_en,
  input  logic [REQW-1:0] req_single,
  input  logic [REQW-1:0] req_burst,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [2:0]      cfg_sel,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic [NCH-1:0]  chan_en,
  output logic [NCH-1:0]  tc_pulse,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [31:0]     mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);
  logic [31:0] src_q [NCH];
  logic [31:0] dst_q [NCH];
  logic [31:0] lli_q [NCH];
  logic [31:0] ctl_q [NCH];
  logic [31:0] cfg_q [NCH];

  st_t            st_q;
  logic [CHW-1:0] cur_q;
  logic [1:0]     dsc_q;
  logic [31:0]    base_q;
  logic [31:0]    buf_q;
  logic [NCH-1:0] tc_q;

  logic [REQW-1:0] req_any;
  logic            hit;
  logic [CHW-1:0]  pick;
  logic [31:0]     c_src, c_dst, c_lli, c_ctl;
  logic [1:0]      s_lg, d_lg;
  logic [11:0]     cnt_nx;
  logic [31:0]     ln_wdata;
  logic [3:0]      ln_be;

  assign req_any = req_single | req_burst;

  dma_ll_arb #(.NCH(NCH), .REQW(REQW), .CHW(CHW)) u_arb (
    .cfg (cfg_q),
    .req (req_any),
    .hit (hit),
    .pick(pick)
  );

  always_comb begin
    c_src  = src_q[cur_q];
    c_dst  = dst_q[cur_q];
    c_lli  = lli_q[cur_q];
    c_ctl  = ctl_q[cur_q];
    s_lg   = wlog(c_ctl[20:18]);
    d_lg   = wlog(c_ctl[23:21]);
    cnt_nx = c_ctl[11:0] - 12'd1;
  end

  dma_ll_lane u_lane (
    .word (buf_q),
    .s_off(c_src[1:0]),
    .s_lg (s_lg),
    .d_off(c_dst[1:0]),
    .d_lg (d_lg),
    .wdata(ln_wdata),
    .wbe  (ln_be)
  );

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    case (st_q)
      S_RD: begin
        mem_valid = 1'b1;
        mem_addr  = c_src;
        mem_be    = lane_mask(s_lg, c_src[1:0]);
      end
      S_WR: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = c_dst;
        mem_be    = ln_be;
        mem_wdata = ln_wdata;
      end
      S_DSC: begin
        mem_valid = 1'b1;
        mem_addr  = base_q + {28'd0, dsc_q, 2'b00};
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = src_q[cfg_ch];
      3'd1:    cfg_rdata = dst_q[cfg_ch];
      3'd2:    cfg_rdata = lli_q[cfg_ch];
      3'd3:    cfg_rdata = ctl_q[cfg_ch];
      3'd4:    cfg_rdata = cfg_q[cfg_ch];
      default: cfg_rdata = '0;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_en
    assign chan_en[c] = cfg_q[c][CF_EN];
  end

  assign tc_pulse = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        lli_q[c] <= '0;
        ctl_q[c] <= '0;
        cfg_q[c] <= '0;
      end
      st_q   <= S_IDLE;
      cur_q  <= '0;
      dsc_q  <= '0;
      base_q <= '0;
      buf_q  <= '0;
      tc_q   <= '0;
    end else begin
      tc_q <= '0;
      if (cfg_we && (int'(cfg_ch) < NCH)) begin
        case (cfg_sel)
          3'd0:    src_q[cfg_ch] <= cfg_wdata;
          3'd1:    dst_q[cfg_ch] <= cfg_wdata;
          3'd2:    lli_q[cfg_ch] <= cfg_wdata;
          3'd3:    ctl_q[cfg_ch] <= cfg_wdata;
          3'd4:    cfg_q[cfg_ch] <= cfg_wdata;
          default: ;
        endcase
      end
      case (st_q)
        S_IDLE: begin
          if (glob_en && hit) begin
            cur_q <= pick;
            st_q  <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ready) begin
            buf_q <= mem_rdata;
            st_q  <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ready) st_q <= S_UPD;
        end
        S_UPD: begin
          if (c_ctl[CT_SINC]) src_q[cur_q] <= c_src + (32'd1 << s_lg);
          if (c_ctl[CT_DINC]) dst_q[cur_q] <= c_dst + (32'd1 << d_lg);
          ctl_q[cur_q] <= {c_ctl[31:12], cnt_nx};
          st_q         <= S_IDLE;
          if (cnt_nx == 12'd0) begin
            if (c_ctl[CT_TCI]) tc_q[cur_q] <= 1'b1;
            if (c_lli != 32'd0) begin
              base_q <= c_lli;
              dsc_q  <= 2'd0;
              st_q   <= S_DSC;
            end else begin
              cfg_q[cur_q][CF_EN] <= 1'b0;
            end
          end
        end
        S_DSC: begin
          if (mem_ready) begin
            case (dsc_q)
              2'd0: src_q[cur_q] <= mem_rdata;
              2'd1: dst_q[cur_q] <= mem_rdata;
              2'd2: lli_q[cur_q] <= mem_rdata;
              2'd3: ctl_q[cur_q] <= mem_rdata;
            endcase
            if (dsc_q == 2'd3) st_q <= S_IDLE;
            else               dsc_q <= dsc_q + 2'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ll_engine_chk.sv
module dma_ll_engine_chk
  import dma_ll_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           glob_en,
  input st_t            st,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_write,
  input logic [31:0]    mem_addr,
  input logic [3:0]     mem_be,
  input logic [31:0]    mem_wdata,
  input logic [NCH-1:0] tc_pulse
);
  a_r1_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) == S_IDLE) |-> $past(glob_en));

  a_r10_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_be) && $stable(mem_wdata)));

  a_r11_lanes_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != 4'h0));

  a_r11_desc_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DSC && mem_valid) |-> (!mem_write && mem_be == 4'hF));

  a_r9_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse));

  a_r9_tc_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |-> ($past(st) == S_UPD));
endmodule

bind dma_ll_engine dma_ll_engine_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glob_en  (glob_en),
  .st       (st_q),
  .mem_valid(mem_valid),
  .mem_ready(mem_ready),
  .mem_write(mem_write),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_wdata(mem_wdata),
  .tc_pulse (tc_pulse)
);

// File: tb/dma_ll_engine_tb.sv
module dma_ll_engine_tb;
  localparam int NCH  = 2;
  localparam int REQW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glob_en = 1'b0;
  logic [REQW-1:0] req_single = '0, req_burst = '0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] chan_en, tc_pulse;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  always #2 clk = ~clk;

  dma_ll_engine #(.NCH(NCH), .REQW(REQW)) u_dut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en),
    .req_single(req_single), .req_burst(req_burst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .chan_en(chan_en), .tc_pulse(tc_pulse),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural memory and reference model
  logic [7:0]  mem [1024];
  logic [31:0] m_src [NCH], m_dst [NCH], m_lli [NCH], m_ctl [NCH], m_cfg [NCH];
  int          tc_exp [NCH], tc_seen [NCH];

  typedef struct { logic [31:0] a; logic w; logic [3:0] be; logic [31:0] d; } acc_t;
  acc_t exq [$];

  function automatic logic [31:0] rd32(input logic [31:0] a);
    int b = int'(a & 32'h3FC);
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  function automatic int ebytes(input logic [2:0] code);
    return (code == 3'd0) ? 1 : (code == 3'd1) ? 2 : 4;
  endfunction

  function automatic bit m_elig(input int c);
    logic [31:0] f = m_cfg[c];
    logic [31:0] rq = 32'(req_single | req_burst);
    bit rs = rq[f[5:1]], rd = rq[f[10:6]], ok;
    case (f[13:11])
      3'd0: ok = 1; 3'd1: ok = rd; 3'd2: ok = rs; 3'd3: ok = rs && rd; default: ok = 0;
    endcase
    return f[0] && !f[18] && ok && glob_en;
  endfunction

  task automatic model_step(output bit found);
    int c = -1;
    for (int k = NCH - 1; k >= 0; k--) if (m_elig(k)) c = k;
    found = (c >= 0);
    if (found) begin
      int sb = ebytes(m_ctl[c][20:18]);
      int db = ebytes(m_ctl[c][23:21]);
      logic [31:0] sa = m_src[c], da = m_dst[c];
      logic [31:0] smk = (sb == 4) ? 32'hFFFFFFFF : ((32'd1 << (8 * sb)) - 1);
      logic [31:0] dmk = (db == 4) ? 32'hFFFFFFFF : ((32'd1 << (8 * db)) - 1);
      logic [31:0] el = (rd32(sa) >> (8 * sa[1:0])) & smk;
      logic [11:0] cn = m_ctl[c][11:0] - 12'd1;
      exq.push_back('{sa, 1'b0, 4'(((1 << sb) - 1) << sa[1:0]), 32'h0});
      exq.push_back('{da, 1'b1, 4'(((1 << db) - 1) << da[1:0]), (el & dmk) << (8 * da[1:0])});
      if (m_ctl[c][26]) m_src[c] = sa + sb;
      if (m_ctl[c][27]) m_dst[c] = da + db;
      if (cn == 0 && m_ctl[c][31]) tc_exp[c]++;
      m_ctl[c] = {m_ctl[c][31:12], cn};
      if (cn == 0) begin
        if (m_lli[c] != 0) begin
          logic [31:0] p = m_lli[c];
          for (int k = 0; k < 4; k++) exq.push_back('{p + 32'(4 * k), 1'b0, 4'hF, 32'h0});
          m_src[c] = rd32(p); m_dst[c] = rd32(p + 4);
          m_lli[c] = rd32(p + 8); m_ctl[c] = rd32(p + 12);
        end else m_cfg[c][0] = 1'b0;
      end
    end
  endtask

  // memory responder, compared against the model on each accepted access
  logic [31:0] cap_a, cap_d; logic cap_w; logic [3:0] cap_be;
  int wcnt = 0, dly = 0;
  bit anyvalid = 0, first_seen = 0;
  logic [31:0] first_a = '0;

  always @(negedge clk) begin
    if (mem_valid) anyvalid = 1;
    for (int c = 0; c < NCH; c++) if (tc_pulse[c]) tc_seen[c]++;
    if (mem_ready) begin
      acc_t e; bit f = 1;
      mem_ready <= 1'b0;
      if (!first_seen) begin first_seen = 1; first_a = cap_a; end
      if (exq.size() == 0) model_step(f);
      if (!f) chk(0, "R4 unexpected access", cap_a, 32'h0);
      else begin
        e = exq.pop_front();
        chk(cap_a == e.a && cap_w == e.w, "R4 R8 access address", cap_a, e.a);
        chk(cap_be == e.be, "R5 R11 byte enables", 32'(cap_be), 32'(e.be));
        if (e.w) chk(cap_d == e.d, "R5 write data", cap_d, e.d);
      end
      if (cap_w) for (int k = 0; k < 4; k++)
        if (cap_be[k]) mem[int'(cap_a & 32'h3FC) + k] = cap_d[8*k +: 8];
      dly = (dly + 1) % 3; wcnt = 0;
    end else if (mem_valid) begin
      if (wcnt >= dly) begin
        cap_a = mem_addr; cap_w = mem_write; cap_be = mem_be; cap_d = mem_wdata;
        mem_rdata <= rd32(mem_addr);
        mem_ready <= 1'b1;
      end else wcnt++;
    end
  end

  function automatic logic [31:0] mreg(input int c, input int s);
    case (s) 0: return m_src[c]; 1: return m_dst[c]; 2: return m_lli[c];
      3: return m_ctl[c]; default: return m_cfg[c]; endcase
  endfunction

  task automatic prog(input int c, input int s, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 1'(c); cfg_sel = 3'(s); cfg_wdata = v;
    case (s) 0: m_src[c] = v; 1: m_dst[c] = v; 2: m_lli[c] = v; 3: m_ctl[c] = v; default: m_cfg[c] = v; endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load(input int c, input logic [31:0] s, d, l, ct, cf);
    prog(c, 0, s); prog(c, 1, d); prog(c, 2, l); prog(c, 3, ct); prog(c, 4, cf);
  endtask

  task automatic rdchk(input int c, input int s, input string tag);
    @(negedge clk);
    cfg_ch = 1'(c); cfg_sel = 3'(s);
    #1 chk(cfg_rdata == mreg(c, s), tag, cfg_rdata, mreg(c, s));
  endtask

  task automatic wait_idle();
    int q = 0, n = 0;
    while (q < 8 && n < 5000) begin
      @(negedge clk); n++;
      if (!mem_valid && exq.size() == 0) q++; else q = 0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    anyvalid = 0;
    repeat (n) @(negedge clk);
    chk(!anyvalid, tag, 32'(anyvalid), 32'h0);
  endtask

  localparam logic [31:0] W44 = (32'd2 << 18) | (32'd2 << 21);
  localparam logic [31:0] INC = (32'd1 << 26) | (32'd1 << 27);
  localparam logic [31:0] TCI = 32'h8000_0000;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_lli[c] = 0; m_ctl[c] = 0; m_cfg[c] = 0;
      tc_exp[c] = 0; tc_seen[c] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_valid && chan_en == 0 && tc_pulse == 0, "R12 reset port state", 32'(mem_valid), 32'h0);
    rdchk(0, 4, "R12 reset config");
    rdchk(1, 3, "R12 reset control");

    // R1: controller disabled holds everything
    load(0, 32'h100, 32'h200, 32'h0, TCI | INC | W44 | 32'd2, 32'h1);
    quiet(30, "R1 no access while disabled");
    glob_en = 1;
    wait_idle();
    chk(chan_en[0] == 1'b0, "R8 channel disabled at end", 32'(chan_en), 32'h0);
    rdchk(0, 3, "R7 count and upper bits");
    rdchk(0, 0, "R6 source advanced");
    rdchk(0, 1, "R6 destination advanced");
    chk(tc_seen[0] == tc_exp[0] && tc_exp[0] == 1, "R9 tc count ch0", 32'(tc_seen[0]), 32'(tc_exp[0]));

    // R2: halt bit blocks, clearing it resumes
    load(0, 32'h108, 32'h210, 32'h0, INC | W44 | 32'd1, 32'h1 | (32'd1 << 18));
    quiet(30, "R2 halted channel idle");
    chk(chan_en[0] == 1'b1, "R2 halted channel still enabled", 32'(chan_en), 32'h1);
    prog(0, 4, 32'h1);
    wait_idle();
    chk(chan_en[0] == 1'b0, "R2 channel ran after halt cleared", 32'(chan_en), 32'h0);

    // R3: flow types
    load(1, 32'h120, 32'h220, 32'h0, INC | W44 | 32'd1, 32'h1 | (32'd2 << 11) | (32'd5 << 1) | (32'd9 << 6));
    quiet(30, "R3 type 2 waits for source line");
    req_burst[5] = 1;
    wait_idle();
    chk(chan_en[1] == 1'b0, "R3 type 2 ran on burst line", 32'(chan_en), 32'h0);
    req_burst = '0; req_single[5] = 1;
    load(1, 32'h124, 32'h224, 32'h0, INC | W44 | 32'd1, 32'h1 | (32'd1 << 11) | (32'd5 << 1) | (32'd9 << 6));
    quiet(30, "R3 type 1 ignores source line");
    req_single[9] = 1;
    wait_idle();
    chk(chan_en[1] == 1'b0, "R3 type 1 ran on dest line", 32'(chan_en), 32'h0);
    req_single = 16'h0200;
    load(1, 32'h128, 32'h228, 32'h0, INC | W44 | 32'd1, 32'h1 | (32'd3 << 11) | (32'd5 << 1) | (32'd9 << 6));
    quiet(30, "R3 type 3 needs both lines");
    req_single = 16'h0220;
    wait_idle();
    chk(chan_en[1] == 1'b0, "R3 type 3 ran with both", 32'(chan_en), 32'h0);
    load(1, 32'h12C, 32'h22C, 32'h0, INC | W44 | 32'd1, 32'h1 | (32'd4 << 11));
    quiet(30, "R3 type 4 never eligible");
    prog(1, 4, 32'h0);
    req_single = '0;

    // R4 and R5: priority and mixed widths
    glob_en = 0;
    load(1, 32'h142, 32'h381, 32'h0, TCI | INC | (32'd1 << 18) | 32'd2, 32'h1);
    load(0, 32'h103, 32'h302, 32'h0, TCI | (32'd1 << 27) | (32'd1 << 21) | 32'd3, 32'h1);
    first_seen = 0;
    glob_en = 1;
    wait_idle();
    chk(first_seen && first_a == 32'h103, "R4 lower index served first", first_a, 32'h103);
    chk(chan_en == 2'b00, "R4 both channels finished", 32'(chan_en), 32'h0);
    rdchk(0, 0, "R6 source held without increment");
    rdchk(0, 1, "R6 halfword destination step");
    rdchk(1, 1, "R6 byte destination step");
    chk(tc_seen[1] == tc_exp[1], "R9 tc count ch1", 32'(tc_seen[1]), 32'(tc_exp[1]));

    // R8: linked descriptors
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d1 [4], d2 [4];
      d1 = '{32'h110, 32'h3A0, 32'h3D0, TCI | INC | W44 | 32'd2};
      d2 = '{32'h120, 32'h3B0, 32'h0, (32'd1 << 27) | 32'd1};
      for (int b = 0; b < 4; b++) begin
        mem[32'h3C0 + 4 * k + b] = d1[k][8*b +: 8];
        mem[32'h3D0 + 4 * k + b] = d2[k][8*b +: 8];
      end
    end
    tc_exp[0] = 0; tc_seen[0] = 0;
    load(0, 32'h104, 32'h390, 32'h3C0, INC | W44 | 32'd1, 32'h1);
    wait_idle();
    chk(chan_en[0] == 1'b0, "R8 chain ended and disabled", 32'(chan_en), 32'h0);
    for (int s = 0; s < 4; s++) rdchk(0, s, "R8 final descriptor registers");
    chk(tc_seen[0] == 1 && tc_exp[0] == 1, "R9 tc only on flagged descriptor", 32'(tc_seen[0]), 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule